// File: doc/BRIEF.md
# Sequential Constant Divider by Digit Lookup

This unit divides an unsigned integer by a small odd constant fixed at elaboration. It does not subtract or multiply. It walks through the dividend one digit of `DIGIT_W` bits per clock cycle, starting at the most significant digit. Each step is a single read from a small table that is computed at elaboration. The table index is the running remainder placed above the current digit. The table entry holds the next quotient digit and the new remainder.

A caller drives `start` high for one cycle together with `dividend` while `busy` is low. `busy` then stays high for one cycle per digit. After that, `done` pulses once. `quotient` and `remainder` carry the result and keep it until the next accepted start. The dividend is padded with zeros at the top to a whole number of digits. The remainder register is reset to zero each time a division is accepted, so consecutive divisions do not affect one another.

Top module: `cdiv_top`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled while `busy` is low raises `busy` at the next edge. `busy` then stays high for exactly ceil(N_BITS/DIGIT_W) cycles (5 with the defaults).
- R3: `done` is high for exactly one cycle. It rises at the same edge where `busy` falls, and `busy` is low whenever `done` is high.
- R4: When `done` is high, `quotient` equals floor(dividend / DIVISOR).
- R5: When `done` is high, `remainder` equals dividend mod DIVISOR, and it is always less than DIVISOR.
- R6: While `busy` is low and no start is accepted, `quotient` and `remainder` do not change.
- R7: A `start` pulse that arrives while `busy` is high is ignored. Neither the running division nor its timing changes.
- R8: A dividend whose width is not a multiple of the digit width is zero-extended at the top. The largest dividend, 2^N_BITS−1, gives the correct quotient and remainder.
- R9: Each accepted start clears the running remainder. A division that follows one ending with a non-zero remainder gives its own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | N_BITS | Unsigned dividend, sampled with an accepted start |
| busy | output | 1 | High while digits are being processed |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | N_BITS | floor(dividend / DIVISOR) |
| remainder | output | REM_W | dividend mod DIVISOR |

## Verification
Internal faults show up at the ports in different ways:

- **Remainder carried between digits:** if it is wrong, the error moves into every later quotient digit. The error therefore shows in both the quotient and the remainder of the same division, at its `done`.
- **Digit counter:** an error changes how long `busy` stays high, which is visible one or more cycles early or late.
- **Remainder not cleared at start:** the fault appears only in the division that follows one that ended with a non-zero remainder. For that reason, the vector order places such pairs next to each other.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Number of whole digits needed to hold a value of the given width.
    function automatic int unsigned digit_count(input int unsigned width, input int unsigned dw);
        return (width + dw - 1) / dw;
    endfunction

    // Bits needed to hold any remainder of division by an odd constant above 1.
    function automatic int unsigned rem_bits(input int unsigned divisor);
        return $clog2(divisor);
    endfunction

endpackage

// File: rtl/cdiv_table.sv
module cdiv_table #(
    parameter int unsigned DIVISOR = 3,
    parameter int unsigned DIGIT_W = 4,
    parameter int unsigned REM_W   = 2
) (
    input  logic [REM_W+DIGIT_W-1:0] idx,
    output logic [DIGIT_W-1:0]       q_dig,
    output logic [REM_W-1:0]         r_dig
);
    localparam int unsigned IDX_W   = REM_W + DIGIT_W;
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [DIGIT_W-1:0] q_tab [ENTRIES];
    logic [REM_W-1:0]   r_tab [ENTRIES];

    // Entries whose remainder part is not below DIVISOR are never indexed.
    // Their truncated values are harmless.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        localparam int unsigned QV = g / DIVISOR;
        localparam int unsigned RV = g % DIVISOR;
        assign q_tab[g] = DIGIT_W'(QV);
        assign r_tab[g] = REM_W'(RV);
    end

    assign q_dig = q_tab[idx];
    assign r_dig = r_tab[idx];
endmodule

// File: rtl/cdiv_count.sv
module cdiv_count #(
    parameter int unsigned NUM_DIG = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic last
);
    localparam int unsigned CNT_W = $clog2(NUM_DIG + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CNT_W'(NUM_DIG);
        else if (step && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
    parameter int unsigned N_BITS  = 18,
    parameter int unsigned DIVISOR = 3,
    parameter int unsigned DIGIT_W = 4,
    localparam int unsigned REM_W  = cdiv_pkg::rem_bits(DIVISOR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_BITS-1:0] dividend,
    output logic              busy,
    output logic              done,
    output logic [N_BITS-1:0] quotient,
    output logic [REM_W-1:0]  remainder
);
    localparam int unsigned NUM_DIG = cdiv_pkg::digit_count(N_BITS, DIGIT_W);
    localparam int unsigned PAD_W   = NUM_DIG * DIGIT_W;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [PAD_W-1:0]  shf;
        logic [N_BITS-1:0] quo;
        logic [REM_W-1:0]  rem;
    } state_t;

    state_t st_d, st_q;

    logic               accept;
    logic               last;
    logic [DIGIT_W-1:0] q_dig;
    logic [REM_W-1:0]   r_dig;

    assign accept = start && !st_q.busy;

    cdiv_table #(
        .DIVISOR (DIVISOR),
        .DIGIT_W (DIGIT_W),
        .REM_W   (REM_W)
    ) u_table (
        .idx   ({st_q.rem, st_q.shf[PAD_W-1 -: DIGIT_W]}),
        .q_dig (q_dig),
        .r_dig (r_dig)
    );

    cdiv_count #(
        .NUM_DIG (NUM_DIG)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (st_q.busy),
        .last  (last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.shf  = PAD_W'(dividend);
            st_d.quo  = '0;
            st_d.rem  = '0;
        end else if (st_q.busy) begin
            st_d.shf = st_q.shf << DIGIT_W;
            st_d.quo = N_BITS'({st_q.quo, q_dig});
            st_d.rem = r_dig;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign quotient  = st_q.quo;
    assign remainder = st_q.rem;
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
    parameter int unsigned N_BITS  = 18,
    parameter int unsigned DIVISOR = 3,
    parameter int unsigned DIGIT_W = 4,
    parameter int unsigned REM_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [N_BITS-1:0] quotient,
    input logic [REM_W-1:0]  remainder
);
    localparam int unsigned NUM_DIG = cdiv_pkg::digit_count(N_BITS, DIGIT_W);
    localparam int unsigned RUN_W   = $clog2(NUM_DIG + 2);

    logic [RUN_W-1:0] run_q;

    // Count the busy cycles since the last accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (start && !busy)   run_q <= '0;
        else if (busy && run_q != '1) run_q <= run_q + 1'b1;
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == RUN_W'(NUM_DIG)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fall_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_rem_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < REM_W'(DIVISOR)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

bind cdiv_top cdiv_checker #(
    .N_BITS  (N_BITS),
    .DIVISOR (DIVISOR),
    .DIGIT_W (DIGIT_W),
    .REM_W   (REM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
    localparam int unsigned N_BITS  = 18;
    localparam int unsigned DIVISOR = 3;
    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned REM_W   = 2;
    localparam int unsigned NUM_DIG = 5;
    localparam int unsigned NVEC    = 12;

    // {dividend, expected quotient, expected remainder}
    localparam logic [N_BITS-1:0] VX [NVEC] = '{
        18'd0, 18'd1, 18'd2, 18'd3, 18'd100, 18'd1000,
        18'd65535, 18'd65536, 18'd262142, 18'd262143, 18'd12345, 18'd200000};
    localparam logic [N_BITS-1:0] VQ [NVEC] = '{
        18'd0, 18'd0, 18'd0, 18'd1, 18'd33, 18'd333,
        18'd21845, 18'd21845, 18'd87380, 18'd87381, 18'd4115, 18'd66666};
    localparam logic [REM_W-1:0] VR [NVEC] = '{
        2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd1,
        2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd2};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N_BITS-1:0] dividend = '0;
    logic              busy, done;
    logic [N_BITS-1:0] quotient;
    logic [REM_W-1:0]  remainder;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cdiv_top #(.N_BITS(N_BITS), .DIVISOR(DIVISOR), .DIGIT_W(DIGIT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder));

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue a start at the next edge. Optionally send an extra start
    // during busy. Check the busy length, the done pulse and the result.
    task automatic run_div(input logic [N_BITS-1:0] x, input logic [N_BITS-1:0] eq,
                           input logic [REM_W-1:0] er, input string tag,
                           input bit poke, input logic [N_BITS-1:0] px);
        @(negedge clk);
        start = 1'b1; dividend = x;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 busy after start"}, busy, 1);
        for (int i = 1; i < NUM_DIG; i++) begin
            if (poke && i == 2) begin
                start = 1'b1; dividend = px;
            end
            @(negedge clk);
            start = 1'b0;
            check({tag, " R2 busy held"}, busy, 1);
            check({tag, " R3 no early done"}, done, 0);
        end
        @(negedge clk);
        check({tag, " R3 done rises"}, done, 1);
        check({tag, " R3 busy low at done"}, busy, 0);
        check({tag, " R4 quotient"}, quotient, eq);
        check({tag, " R5 remainder"}, remainder, er);
        @(negedge clk);
        check({tag, " R3 done one cycle"}, done, 0);
        check({tag, " R6 quotient kept"}, quotient, eq);
        check({tag, " R6 remainder kept"}, remainder, er);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is applied and after release
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 quotient", quotient, 0);
        check("R1 remainder", remainder, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", busy, 0);

        // Vector walk. Entry 3 follows entry 2 (remainder 2): R9.
        for (int v = 0; v < NVEC; v++) begin
            run_div(VX[v], VQ[v], VR[v], (v == 3) ? "R9 vec" : "R4 vec", 1'b0, '0);
            // The bench also derives the result on its own.
            check("R4 table sanity", VQ[v], VX[v] / DIVISOR);
        end

        // R8: all-ones dividend, top digit only partly filled.
        run_div(18'h3FFFF, 18'd87381, 2'd0, "R8 max", 1'b0, '0);

        // R7: a start during busy must not disturb the run.
        run_div(18'd1000, 18'd333, 2'd1, "R7 ignore", 1'b1, 18'd7);

        // R9: non-zero remainder, then a dividend divisible by 3.
        run_div(18'd200000, 18'd66666, 2'd2, "R9 first", 1'b0, '0);
        run_div(18'd99, 18'd33, 2'd0, "R9 second", 1'b0, '0);

        // R6: long idle period, outputs unchanged.
        repeat (10) @(negedge clk);
        check("R6 idle quotient", quotient, 33);
        check("R6 idle remainder", remainder, 0);
        check("R6 idle busy", busy, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule